// File: doc/BRIEF.md
# Scattered-Pilot Time Extrapolator

The block builds a per-subcarrier channel estimate for the current OFDM symbol from scattered pilots. Pilots sit on every twelfth subcarrier, and their offset moves up by three subcarriers from one symbol to the next, so the pattern repeats every four symbols. The block keeps the pilot responses of the seven most recent symbols in seven rotating banks. On the three-subcarrier grid of the current symbol, one grid point in four is a measured pilot. The other three are predicted by linear extrapolation along time from two earlier symbols that had a pilot at that position. Linear interpolation along frequency then fills the two subcarriers between neighbouring grid points.

Channel responses arrive as one complex sample per cycle. A `sym_start` strobe marks subcarrier 0, and the next `12*NGRP-1` cycles carry the rest of the symbol. Only the samples at pilot positions are used. Estimates leave the block as a stream of `12*NGRP` consecutive cycles, each tagged with its subcarrier index. The stream starts 24 cycles after the matching input subcarrier. Consecutive `sym_start` strobes must be at least `12*NGRP+12` cycles apart.

Top module: `sp_time_extrap`

## Requirements
- R1: During reset and after it, until the first symbol's estimates are due, `est_valid` and `est_ok` are low.
- R2: Symbols are numbered from 0, starting at the first `sym_start` after reset. Each symbol's pilots go into one of seven banks, taken in rotation, and overwrite the oldest symbol. Estimates for symbol n use the pilots of symbols n-1 to n-7.
- R3: Subcarrier k is a pilot of symbol n when k mod 12 equals 3·(n mod 4). At a grid point (k mod 3 = 0) three subcarriers above the current pilot phase, counted modulo 12, the grid value is floor((7·P(n-3) − 3·P(n-7))/4), taken per component.
- R4: At a grid point six above the phase, the grid value is floor((6·P(n-2) − 2·P(n-6))/4).
- R5: At a grid point nine above the phase, the grid value is floor((5·P(n-1) − P(n-5))/4).
- R6: At a pilot position of symbol n, the estimate equals the sample received there.
- R7: Every computed value saturates to the signed `W`-bit range and never wraps.
- R8: Let a be the grid value just below subcarrier k and b the grid value just above it. With k mod 3 = 1 the estimate is floor((2a+b)·171/512); with k mod 3 = 2 it is floor((a+2b)·171/512). Both are saturated.
- R9: The last grid point has no upper neighbour. The two subcarriers above it repeat its value.
- R10: Input subcarrier k of a symbol produces output `est_idx` = k exactly 24 cycles later, with `est_valid` high. The `12*NGRP` outputs come on consecutive cycles and are followed by a cycle with `est_valid` low.
- R11: `est_ok` is high through the whole output stream of symbol 7 and of every later symbol, and low for symbols 0 to 6.
- R12: Samples at non-pilot subcarriers have no effect on any estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_start | input | 1 | Marks subcarrier 0 of a new symbol |
| pil_re | input | W | Real part of the channel response at the current subcarrier |
| pil_im | input | W | Imaginary part of the channel response at the current subcarrier |
| est_valid | output | 1 | Estimate on the outputs is valid |
| est_ok | output | 1 | Seven previous symbols were available for this estimate |
| est_idx | output | clog2(12·NGRP) | Subcarrier index of the estimate |
| est_re | output | W | Real part of the estimate |
| est_im | output | W | Imaginary part of the estimate |

## Verification
The bench builds the block with W = 12 and NGRP = 4. With 48 subcarriers per symbol there are four groups, so the stream's interior groups and its last group are both covered. The 12-bit width lets full-scale pilot histories drive both extrapolation and interpolation into saturation at either rail. Fourteen symbols cover every pilot phase more than twice, pass through the bank rotation twice, and cross the point where `est_ok` rises.

// File: rtl/sp_time_extrap.sv
module sp_time_extrap #(
  parameter int W    = 12,
  parameter int NGRP = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sym_start,
  input  logic signed [W-1:0]               pil_re,
  input  logic signed [W-1:0]               pil_im,
  output logic                              est_valid,
  output logic                              est_ok,
  output logic [$clog2(12*NGRP)-1:0]        est_idx,
  output logic signed [W-1:0]               est_re,
  output logic signed [W-1:0]               est_im
);
  localparam int NCAR = 12 * NGRP;
  localparam int KW   = $clog2(NCAR);
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int PW   = W + 11;
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  typedef logic signed [W-1:0] smp_t;

  function automatic smp_t sat(input logic signed [PW-1:0] v);
    if (v > PW'(SMAX)) return SMAX;
    if (v < PW'(SMIN)) return SMIN;
    return v[W-1:0];
  endfunction

  function automatic smp_t extrap(input logic [1:0] d, input smp_t a, input smp_t b);
    logic signed [PW-1:0] x, y, t;
    x = PW'(a);
    y = PW'(b);
    case (d)
      2'd1:    t = ((x <<< 3) - x) - ((y <<< 1) + y);
      2'd2:    t = ((x <<< 2) + (x <<< 1)) - (y <<< 1);
      default: t = ((x <<< 2) + x) - y;
    endcase
    return sat(t >>> 2);
  endfunction

  function automatic smp_t third(input smp_t a, input smp_t b);
    logic signed [PW-1:0] v;
    v = (PW'(a) <<< 1) + PW'(b);
    return sat(((v <<< 7) + (v <<< 5) + (v <<< 3) + (v <<< 1) + v) >>> 9);
  endfunction

  function automatic logic [2:0] bank_of(input logic [2:0] b, input int age);
    int t;
    t = (int'(b) + 7 - age) % 7;
    return 3'(t);
  endfunction

  smp_t bufm [7][NGRP][2];
  smp_t hold [6][2];
  smp_t cur  [2];
  smp_t ga   [4][2];
  smp_t gb   [4][2];
  smp_t gn   [4][2];
  smp_t pin  [2];

  logic [2:0]    sptr;
  logic [1:0]    ph;
  logic [3:0]    scnt;
  logic          iact;
  logic [3:0]    ij;
  logic [GW-1:0] ig;
  logic          oact, ook;
  logic [3:0]    oj;
  logic [GW-1:0] og;

  logic [2:0]    nptr, bsel;
  logic [1:0]    phs;
  logic          act, pil_hit;
  logic [3:0]    cj;
  logic [GW-1:0] cg;

  assign nptr    = (sptr == 3'd6) ? 3'd0 : sptr + 3'd1;
  assign bsel    = sym_start ? nptr : sptr;
  assign phs     = sym_start ? ph + 2'd1 : ph;
  assign act     = sym_start | iact;
  assign cj      = sym_start ? 4'd0 : ij;
  assign cg      = sym_start ? '0 : ig;
  assign pin[0]  = pil_re;
  assign pin[1]  = pil_im;
  assign pil_hit = act && (cj == ({1'b0, phs, 1'b0} + {2'b00, phs}));

  // hold slots carry ages 1,2,3,5,6,7
  always_comb begin
    for (int q = 0; q < 4; q++) begin
      for (int c = 0; c < 2; c++) begin
        case (2'(q) - ph)
          2'd0:    gn[q][c] = cur[c];
          2'd1:    gn[q][c] = extrap(2'd1, hold[2][c], hold[5][c]);
          2'd2:    gn[q][c] = extrap(2'd2, hold[1][c], hold[4][c]);
          default: gn[q][c] = extrap(2'd3, hold[0][c], hold[3][c]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sptr <= 3'd6;
      ph   <= 2'd3;
      scnt <= 4'd0;
      iact <= 1'b0;
      ij   <= 4'd0;
      ig   <= '0;
      oact <= 1'b0;
      ook  <= 1'b0;
      oj   <= 4'd0;
      og   <= '0;
      for (int c = 0; c < 2; c++) begin
        cur[c] <= '0;
        for (int i = 0; i < 6; i++) hold[i][c] <= '0;
        for (int q = 0; q < 4; q++) begin
          ga[q][c] <= '0;
          gb[q][c] <= '0;
        end
        for (int b = 0; b < 7; b++)
          for (int g = 0; g < NGRP; g++) bufm[b][g][c] <= '0;
      end
    end else begin
      if (sym_start) begin
        sptr <= nptr;
        ph   <= ph + 2'd1;
        if (scnt != 4'd8) scnt <= scnt + 4'd1;
      end
      if (act) begin
        if (cj == 4'd11) begin
          ij <= 4'd0;
          ga <= gn;
          gb <= ga;
          if (cg == GW'(NGRP - 1)) iact <= 1'b0;
          else begin
            iact <= 1'b1;
            ig   <= cg + 1'b1;
          end
        end else begin
          iact <= 1'b1;
          ij   <= cj + 4'd1;
          ig   <= cg;
        end
        if (cj == 4'd0) begin
          for (int i = 0; i < 6; i++)
            hold[i] <= bufm[bank_of(bsel, (i < 3) ? i + 1 : i + 2)][cg];
        end
        if (pil_hit) begin
          cur             <= pin;
          bufm[bsel][cg]  <= pin;
        end
      end
      if (oact) begin
        if (oj == 4'd11) begin
          oj <= 4'd0;
          if (og == GW'(NGRP - 1)) oact <= 1'b0;
          else og <= og + 1'b1;
        end else begin
          oj <= oj + 4'd1;
        end
      end
      if (act && cg == GW'(1) && cj == 4'd11) begin
        oact <= 1'b1;
        oj   <= 4'd0;
        og   <= '0;
        ook  <= (scnt == 4'd8);
      end
    end
  end

  logic       last;
  logic [1:0] oq, orr;
  smp_t       pa [2];
  smp_t       pb [2];
  smp_t       ov [2];

  always_comb begin
    last = (og == GW'(NGRP - 1));
    oq   = 2'(oj / 4'd3);
    orr  = 2'(oj % 4'd3);
    for (int c = 0; c < 2; c++) begin
      pa[c] = last ? ga[oq][c] : gb[oq][c];
      if (oq == 2'd3) pb[c] = last ? ga[3][c] : ga[0][c];
      else            pb[c] = last ? ga[oq + 2'd1][c] : gb[oq + 2'd1][c];
      if (orr == 2'd0 || (last && oq == 2'd3)) ov[c] = pa[c];
      else if (orr == 2'd1)                    ov[c] = third(pa[c], pb[c]);
      else                                     ov[c] = third(pb[c], pa[c]);
    end
  end

  assign est_valid = oact;
  assign est_ok    = oact & ook;
  assign est_idx   = KW'(og) * KW'(12) + KW'(oj);
  assign est_re    = ov[0];
  assign est_im    = ov[1];
endmodule

module sp_time_extrap_chk #(
  parameter int NGRP = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       est_valid,
  input logic                       est_ok,
  input logic [$clog2(12*NGRP)-1:0] est_idx
);
  localparam int NCAR = 12 * NGRP;
  localparam int KW   = $clog2(NCAR);

  logic seen_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_ok <= 1'b0;
    else if (est_valid && est_ok) seen_ok <= 1'b1;
  end

  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid && est_idx != KW'(NCAR - 1) |=> est_valid && est_idx == $past(est_idx) + KW'(1));
  // R10
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid && est_idx == KW'(NCAR - 1) |=> !est_valid);
  // R10
  stream_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(est_valid) |-> est_idx == '0);
  // R11
  ok_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid && $past(est_valid) |-> $stable(est_ok));
  // R11
  ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid && seen_ok |-> est_ok);
endmodule

bind sp_time_extrap sp_time_extrap_chk #(.NGRP(NGRP)) i_chk (
  .clk(clk), .rst_n(rst_n), .est_valid(est_valid), .est_ok(est_ok), .est_idx(est_idx)
);

// File: tb/test_sp_time_extrap.sv
module test_sp_time_extrap;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 12;
  localparam int NGRP = 4;
  localparam int NCAR = 12 * NGRP;
  localparam int NSYM = 14;
  localparam int GAP  = 14;
  localparam int LAT  = 24;
  localparam int VMAX = (1 << (W - 1)) - 1;
  localparam int VMIN = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_start = 1'b0;
  logic signed [W-1:0] pil_re = '0;
  logic signed [W-1:0] pil_im = '0;
  logic est_valid, est_ok;
  logic [$clog2(NCAR)-1:0] est_idx;
  logic signed [W-1:0] est_re, est_im;

  sp_time_extrap #(.W(W), .NGRP(NGRP)) i_sp_time_extrap (
    .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .pil_re(pil_re), .pil_im(pil_im),
    .est_valid(est_valid), .est_ok(est_ok), .est_idx(est_idx), .est_re(est_re), .est_im(est_im)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int hist [NSYM][NGRP][2];
  int start_cyc [NSYM];
  int osym = 0, ek = 0, nout = 0;
  bit done = 1'b0;
  int modes [NSYM] = '{0, 2, 0, 3, 1, 2, 1, 1, 1, 1, 2, 0, 3, 0};

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int satw(input int v);
    return (v > VMAX) ? VMAX : (v < VMIN) ? VMIN : v;
  endfunction

  function automatic int grid(input int n, input int g, input int q, input int c);
    int d;
    d = (q - (n % 4) + 4) % 4;
    case (d)
      0: return hist[n][g][c];
      1: return satw((7 * hist[n-3][g][c] - 3 * hist[n-7][g][c]) >>> 2);
      2: return satw((6 * hist[n-2][g][c] - 2 * hist[n-6][g][c]) >>> 2);
      default: return satw((5 * hist[n-1][g][c] - hist[n-5][g][c]) >>> 2);
    endcase
  endfunction

  function automatic int expv(input int n, input int k, input int c);
    int g, j, q, r, a, b;
    g = k / 12; j = k % 12; q = j / 3; r = j % 3;
    a = grid(n, g, q, c);
    if (r == 0 || (g == NGRP - 1 && q == 3)) return a;
    b = (q < 3) ? grid(n, g, q + 1, c) : grid(n, g + 1, 0, c);
    if (r == 1) return satw(((2 * a + b) * 171) >>> 9);
    return satw(((a + 2 * b) * 171) >>> 9);
  endfunction

  function automatic string tagof(input int n, input int k, input int v);
    int j, q, d;
    string s;
    j = k % 12; q = j / 3;
    d = (q - (n % 4) + 4) % 4;
    if (j % 3 != 0) s = ((k / 12 == NGRP - 1) && q == 3) ? "R9" : "R8 R12";
    else if (d == 0) s = "R6 R12";
    else if (d == 1) s = "R3 R2 R12";
    else if (d == 2) s = "R4 R2 R12";
    else s = "R5 R2 R12";
    if (v == VMAX || v == VMIN) s = {s, " R7"};
    return s;
  endfunction

  function automatic int genv(input int mode);
    case (mode)
      1: return VMAX;
      2: return VMIN;
      3: return int'($urandom % 17) - 8;
      default: return int'($urandom % (1 << W)) + VMIN;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1 valid in reset", int'(est_valid), 0);
      check("R1 ok in reset", int'(est_ok), 0);
    end else if (est_valid && !done) begin
      if (osym >= NSYM) check("R10 extra output", 1, 0);
      else begin
        if (ek == 0) check("R10 latency", cyc, start_cyc[osym] + LAT);
        check("R10 index", int'(est_idx), ek);
        check("R11 ok flag", int'(est_ok), (osym >= 7) ? 1 : 0);
        if (osym >= 7) begin
          for (int c = 0; c < 2; c++) begin
            int e;
            e = expv(osym, ek, c);
            check(tagof(osym, ek, e), (c == 0) ? int'(est_re) : int'(est_im), e);
          end
        end
        nout++;
        ek++;
        if (ek == NCAR) begin
          ek = 0;
          osym++;
        end
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 idle valid", int'(est_valid), 0);
    check("R1 idle ok", int'(est_ok), 0);
    for (int n = 0; n < NSYM; n++) begin
      for (int k = 0; k < NCAR; k++) begin
        @(negedge clk);
        if (k == 0) start_cyc[n] = cyc;
        sym_start = (k == 0);
        if (k % 12 == 3 * (n % 4)) begin
          hist[n][k / 12][0] = genv(modes[n]);
          hist[n][k / 12][1] = genv((modes[n] == 1) ? 2 : (modes[n] == 2) ? 1 : modes[n]);
          pil_re = W'(hist[n][k / 12][0]);
          pil_im = W'(hist[n][k / 12][1]);
        end else begin
          pil_re = W'(genv(0));
          pil_im = W'(genv(0));
        end
      end
      for (int i = 0; i < GAP; i++) begin
        @(negedge clk);
        sym_start = 1'b0;
        pil_re = W'(genv(0));
        pil_im = W'(genv(0));
      end
    end
    repeat (LAT + 20) @(negedge clk);
    check("R10 output count", nout, NSYM * NCAR);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual %0d expected below 5000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule